// File: doc/BRIEF.md
# Serial Shift-In Register with External Clock

This block captures a serial bit stream into a parallel register. An external shift clock and a serial data line arrive from outside the chip. Both pass through synchronisers into the system clock domain. A rising edge of the shift clock moves the register contents one place toward the most significant bit and places the new bit in bit 0. After eight bits, the first bit received therefore sits in the MSB.

The register never stops shifting. Once it is full, each further shift drops the oldest bit, so it always holds the most recent bits as a rolling window. Software may read the register at any time, including between edges when only some bits have arrived. A 3-bit counter counts shifts. When it completes a group of eight shifts, a flag rises. Any read or write of the register clears the flag and restarts the count. A mode-enable input gates shifting, and an enable bit masks the interrupt output.

Top module: `ext_shift_in`

## Requirements
- R1: After reset, the register reads 0x00, and both the flag and the interrupt output are 0.
- R2: Each shift moves bits [6:0] into [7:1] and puts the sampled data bit in bit 0. After eight shifts, the first bit received is bit 7.
- R3: With two synchroniser stages, a rising shift-clock edge presented just after a system clock edge changes the register at the 4th following system clock edge and not earlier. A falling edge causes no shift.
- R4: Shifting continues past eight bits, and each further shift discards the current bit 7.
- R5: The flag rises on the eighth shift since the last register access and stays 0 after seven.
- R6: A read access (sel=1, rd_en=1) clears the flag at the next edge and restarts the shift count from zero.
- R7: A write access (sel=1, wr_en=1) loads wr_data into the register, clears the flag and restarts the count.
- R8: The register contents are unchanged between shifts, so a partial result is readable after any number of shifts.
- R9: While shift_en is 0, shift-clock edges leave the register and the shift count unchanged. Counting resumes from the held value when shift_en returns to 1.
- R10: irq is 1 exactly when the flag is 1 and irq_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External shift clock (asynchronous) |
| ext_dat | input | 1 | Serial data input (asynchronous) |
| shift_en | input | 1 | Mode enable; 1 allows shifting |
| sel | input | 1 | Register select for accesses |
| rd_en | input | 1 | Read strobe; clears flag and count |
| wr_en | input | 1 | Write strobe; loads wr_data |
| wr_data | input | 8 | Data to load on a write |
| rd_data | output | 8 | Current register contents |
| irq_en | input | 1 | Interrupt enable |
| irq_flag | output | 1 | Eight-shift flag |
| irq | output | 1 | Flag gated by irq_en |

## Verification
A rising shift-clock edge driven at a falling system clock edge reaches the register four rising edges later: two synchroniser stages, the edge pulse register, then the register itself. The flag is due on that same fourth edge of the eighth shift. The bench drives at falling edges and samples at falling edges. It checks that the register is still unchanged after the third rising edge and updated after the fourth. Every other check waits six cycles after each clock transition, so each result has settled before it is sampled. Accesses are single-cycle strobes, and their effect on the flag and register is checked at the next falling edge.

// File: rtl/esi_pkg.sv
package esi_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    // a write dominates a read when both strobes are present
    function automatic acc_e decode_access(input logic sel, input logic rd, input logic wr);
        if (!sel)   return ACC_NONE;
        else if (wr) return ACC_WRITE;
        else if (rd) return ACC_READ;
        else         return ACC_NONE;
    endfunction

endpackage

// File: rtl/esi_sync.sv
module esi_sync #(
    parameter int STAGES = 2,
    parameter int N      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            logic [N-1:0] stage_d;
            if (s == 0) begin : g_first
                assign stage_d = din;
            end else begin : g_next
                assign stage_d = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_d;
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/esi_rise.sv
module esi_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic pulse
);
    typedef struct packed {
        logic prev;
        logic pulse;
    } rise_t;

    rise_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.prev  = lvl;
        r_d.pulse = lvl & ~r_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pulse = r_q.pulse;
endmodule

// File: rtl/ext_shift_in.sv
module ext_shift_in #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ext_clk,
    input  logic         ext_dat,
    input  logic         shift_en,
    input  logic         sel,
    input  logic         rd_en,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    input  logic         irq_en,
    output logic         irq_flag,
    output logic         irq
);
    import esi_pkg::*;

    localparam int          CW   = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  sr;
        logic [CW-1:0] cnt;
        logic          flag;
    } state_t;

    logic [1:0] sync_out;
    logic       edge_pulse;
    logic       shift_fire;
    logic       acc_hit;
    logic       wr_hit;
    acc_e       acc;
    state_t     st_d, st_q;

    esi_sync #(.STAGES(SYNC_STAGES), .N(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ext_clk, ext_dat}),
        .dout (sync_out)
    );

    esi_rise u_rise (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (sync_out[1]),
        .pulse(edge_pulse)
    );

    assign shift_fire = edge_pulse & shift_en;
    assign acc        = decode_access(sel, rd_en, wr_en);
    assign acc_hit    = (acc != ACC_NONE);
    assign wr_hit     = (acc == ACC_WRITE);

    always_comb begin
        st_d = st_q;
        if (shift_fire) begin
            st_d.sr = {st_q.sr[W-2:0], sync_out[0]};
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.flag = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (acc_hit) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
        end
        if (wr_hit) begin
            st_d.sr = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data  = st_q.sr;
    assign irq_flag = st_q.flag;
    assign irq      = st_q.flag & irq_en;
endmodule

// File: rtl/esi_checker.sv
module esi_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         shift_fire,
    input logic         acc_hit,
    input logic         wr_hit,
    input logic         shift_en,
    input logic         irq_en,
    input logic         irq,
    input logic         irq_flag,
    input logic [W-1:0] rd_data
);
    a_r2_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(shift_fire) && !$past(wr_hit)) |-> (rd_data[W-1:1] == $past(rd_data[W-2:0])));

    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(shift_fire) && !$past(wr_hit)) |-> $stable(rd_data));

    a_r6_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hit |=> !irq_flag);

    a_r5_flag_from_shift: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(shift_fire));

    a_r9_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !acc_hit) |=> ($stable(rd_data) && $stable(irq_flag)));

    a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

bind ext_shift_in esi_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_fire(shift_fire),
    .acc_hit   (acc_hit),
    .wr_hit    (wr_hit),
    .shift_en  (shift_en),
    .irq_en    (irq_en),
    .irq       (irq),
    .irq_flag  (irq_flag),
    .rd_data   (rd_data)
);

// File: tb/ext_shift_in_test.sv
module ext_shift_in_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0, ext_dat = 1'b0, shift_en = 1'b0;
    logic       sel = 1'b1, rd_en = 1'b0, wr_en = 1'b0, irq_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_flag, irq;
    logic [7:0] model = 8'h00;
    int         total = 0, bad = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    ext_shift_in uut (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .ext_dat(ext_dat),
        .shift_en(shift_en), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq_en(irq_en),
        .irq_flag(irq_flag), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one full external clock period; model follows only when shifting is enabled
    task automatic shift_bit(input logic b);
        @(negedge clk);
        ext_dat = b;
        ext_clk = 1'b1;
        repeat (6) @(negedge clk);
        ext_clk = 1'b0;
        repeat (6) @(negedge clk);
        if (shift_en) model = {model[6:0], b};
    endtask

    task automatic do_read();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
        model = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 data", rd_data, 8'h00);
        chk("R1 flag", {7'd0, irq_flag}, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        shift_en = 1'b1;
        irq_en   = 1'b1;

        // R3 latency: rise at a falling edge, update at the 4th rising edge
        ext_dat = 1'b1; ext_clk = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 not yet", rd_data, 8'h00);
        @(negedge clk);
        chk("R3 on time", rd_data, 8'h01);
        repeat (2) @(negedge clk);
        ext_dat = 1'b0; ext_clk = 1'b0;
        repeat (8) @(negedge clk);
        chk("R3 fall no shift", rd_data, 8'h01);
        model = 8'h01;
        do_read();

        // R2, R5, R8, R10 sweep over every byte
        for (int v = 0; v < 256; v++) begin
            do_read();
            for (int i = 7; i >= 0; i--) begin
                shift_bit(v[i]);
                if (i == 4) chk("R8 partial", {4'h0, rd_data[3:0]}, {4'h0, 4'(v >> 4)});
                if (i == 1) chk("R5 seven shifts", {7'd0, irq_flag}, 8'h00);
            end
            chk("R2 order", rd_data, 8'(v));
            chk("R5 eighth shift", {7'd0, irq_flag}, 8'h01);
            chk("R10 irq on", {7'd0, irq}, 8'h01);
        end

        // R4 rolling window
        for (int i = 0; i < 3; i++) shift_bit(i[0]);
        chk("R4 rolling", rd_data, model);
        chk("R4 flag held", {7'd0, irq_flag}, 8'h01);

        // R10 masking
        @(negedge clk); irq_en = 1'b0;
        @(negedge clk);
        chk("R10 masked", {7'd0, irq}, 8'h00);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R10 unmasked", {7'd0, irq}, 8'h01);

        // R6 read clears and restarts
        do_read();
        chk("R6 cleared", {7'd0, irq_flag}, 8'h00);
        chk("R6 data kept", rd_data, model);
        for (int i = 0; i < 7; i++) shift_bit(1'b1);
        chk("R6 seven after read", {7'd0, irq_flag}, 8'h00);
        shift_bit(1'b0);
        chk("R6 eight after read", {7'd0, irq_flag}, 8'h01);
        chk("R6 data", rd_data, model);

        // R7 write loads, clears and restarts
        do_write(8'hA5);
        chk("R7 load", rd_data, 8'hA5);
        chk("R7 cleared", {7'd0, irq_flag}, 8'h00);
        for (int i = 0; i < 7; i++) shift_bit(1'b0);
        chk("R7 seven after write", {7'd0, irq_flag}, 8'h00);
        chk("R7 data", rd_data, model);
        shift_bit(1'b1);
        chk("R7 eight after write", {7'd0, irq_flag}, 8'h01);

        // R9 mode enable gates shifting and holds the count
        do_read();
        for (int i = 0; i < 3; i++) shift_bit(1'b1);
        shift_en = 1'b0;
        for (int i = 0; i < 4; i++) shift_bit(1'b0);
        chk("R9 data held", rd_data, model);
        chk("R9 no flag", {7'd0, irq_flag}, 8'h00);
        shift_en = 1'b1;
        for (int i = 0; i < 4; i++) shift_bit(1'b0);
        chk("R9 count held", {7'd0, irq_flag}, 8'h00);
        shift_bit(1'b1);
        chk("R9 resumed", {7'd0, irq_flag}, 8'h01);
        chk("R9 data", rd_data, model);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule